// File: doc/BRIEF.md
# Triggered Exposure Sequencer

This block runs one externally triggered exposure of a progressive-scan image sensor. It counts pixel clocks from each line sync and looks at its control inputs (trigger, early-readout request, discharge request, frame sync) only once per line, a fixed number of clocks after the line sync is seen. A falling trigger arms the sequencer. At the next line sync it goes busy, fires one substrate discharge pulse that starts the exposure, and later fires the charge readout pulse. The exposure ends when a programmed number of lines has elapsed, or after a fixed flicker-reduction line count, or earlier when an early-readout request arrives.

When the sequencer is neither busy nor armed, a frame sync falling edge gives a plain readout pulse and busy stays low. While busy, frame sync is ignored. If two or more of the trigger, early-readout and discharge requests fall in the same sample, that sample is discarded and a one-clock error pulse is raised. The discharge request has no other use in this block.

Top module: `trig_exposure_ctrl`

## Requirements
- R1: During and after reset, `busy_o`, `sub_o`, `readout_o` and `err_o` are low.
- R2: A trigger falling edge seen in a sample, with `shutter_mode` equal to 2'b10 (line-count exposure) or 2'b00 (flicker-reduction exposure), arms the sequencer. `busy_o` then rises at the following line sync.
- R3: With `shutter_mode` equal to 2'b11 (shutter off) or 2'b01 (slow shutter), a trigger edge is rejected: `busy_o` and `readout_o` stay low.
- R4: In mode 2'b10, `readout_o` rises `line_count`·CLKS_PER_LINE + ACCUM_CLKS clocks after `sub_o` falls. A `line_count` of 0 acts as 1.
- R5: In mode 2'b00, the same interval uses FLICKER_LINES in place of `line_count`.
- R6: `sub_o` is high for exactly SUB_WIDTH clocks in each triggered exposure. It rises SUB_START clocks after `busy_o` rises and is never high while `busy_o` is low.
- R7: `readout_o` is high for READ_WIDTH clocks. After a triggered readout, `busy_o` falls CLKS_PER_LINE clocks after `readout_o` falls.
- R8: With `early_mode_n` low, an early-request falling edge seen in a sample while exposing raises `readout_o` on the clock after that sample. Only one readout is produced per trigger.
- R9: With `early_mode_n` high, early-request edges leave the exposure time unchanged.
- R10: With the block idle, a frame sync falling edge gives one readout pulse while `busy_o` stays low. While `busy_o` is high, frame sync edges change neither the pulse count nor the timing.
- R11: When two or more of trigger, early request and discharge request fall in one sample, `err_o` pulses for one clock and that sample causes no state change.
- R12: An input that goes low and returns high between two samples has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_sync_n | input | 1 | Line sync, active-low, asynchronous |
| frame_sync_n | input | 1 | Frame sync, active-low, asynchronous |
| trig_n | input | 1 | Exposure trigger, falling edge acts |
| early_n | input | 1 | Early-readout request, falling edge acts |
| discharge_n | input | 1 | Discharge request, used only for clash detection |
| early_mode_n | input | 1 | Low enables early readout |
| shutter_mode | input | 2 | 10 line count, 00 flicker, 11 off, 01 slow |
| line_count | input | LCNT_W | Exposure length in lines for mode 10 |
| busy_o | output | 1 | High during a triggered exposure |
| sub_o | output | 1 | Substrate discharge pulse |
| readout_o | output | 1 | Charge readout pulse |
| err_o | output | 1 | One-clock pulse on a request clash |

## Verification
The bench measures the gap from the falling edge of the substrate pulse to the rising edge of the readout pulse. An off-by-one in the line countdown or in the accumulation offset shifts this gap by a whole line or by one clock. It also covers a zero line count, the two rejected modes and the flicker count, which a wrong mode decode would turn into a stray exposure or a wrong length. It drops an early request, a frame sync during busy and a sub-line glitch on the trigger. A design that samples outside its window, honours frame sync while busy, or ignores the early-mode pin would add a readout or move its timing. A simultaneous trigger and early request must give only the error pulse and must not arm the block.

// File: rtl/trig_exposure_ctrl.sv
module trig_exposure_ctrl #(
  parameter int CLKS_PER_LINE = 780,
  parameter int FLICKER_LINES = 315,
  parameter int ACCUM_CLKS    = 456,
  parameter int SUB_START     = 40,
  parameter int SUB_WIDTH     = 40,
  parameter int WIN_OFS       = 2,
  parameter int READ_WIDTH    = 56,
  parameter int LCNT_W        = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_sync_n,
  input  logic              frame_sync_n,
  input  logic              trig_n,
  input  logic              early_n,
  input  logic              discharge_n,
  input  logic              early_mode_n,
  input  logic [1:0]        shutter_mode,
  input  logic [LCNT_W-1:0] line_count,
  output logic              busy_o,
  output logic              sub_o,
  output logic              readout_o,
  output logic              err_o
);
  localparam int POS_W   = $clog2(CLKS_PER_LINE + 1);
  localparam int SUB_END = SUB_START + SUB_WIDTH;
  localparam int RD_POS  = SUB_END + ACCUM_CLKS;

  typedef enum logic [2:0] {
    S_IDLE, S_ARMED, S_EXPOSE, S_ACCUM, S_READ, S_HOLD, S_NREAD
  } st_t;

  st_t               st;
  logic [4:0]        s1, s2;
  logic              hs_d;
  logic [3:0]        prev;
  logic [POS_W-1:0]  pos, cnt;
  logic [LCNT_W-1:0] rem;
  logic              flick, first, err_q;

  logic       hs_evt, samp, clash, mode_ok, early_go;
  logic [3:0] falls;

  assign hs_evt   = hs_d & ~s2[4];
  assign samp     = (pos == POS_W'(WIN_OFS)) & ~hs_evt;
  assign falls    = {4{samp}} & prev & ~s2[3:0];
  assign clash    = (falls[2] & falls[1]) | (falls[2] & falls[0]) | (falls[1] & falls[0]);
  assign mode_ok  = (shutter_mode == 2'b10) || (shutter_mode == 2'b00);
  assign early_go = falls[1] & ~clash & ~early_mode_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= '1;
      s2   <= '1;
      hs_d <= 1'b1;
      prev <= '1;
      pos  <= '1;
    end else begin
      s1   <= {line_sync_n, frame_sync_n, trig_n, early_n, discharge_n};
      s2   <= s1;
      hs_d <= s2[4];
      if (samp) prev <= s2[3:0];
      if (hs_evt) pos <= '0;
      else if (pos != '1) pos <= pos + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      rem   <= '0;
      flick <= 1'b0;
      first <= 1'b0;
      err_q <= 1'b0;
    end else begin
      err_q <= clash;
      case (st)
        S_IDLE: begin
          if (!clash) begin
            if (falls[2] && mode_ok) begin
              st    <= S_ARMED;
              flick <= (shutter_mode == 2'b00);
            end else if (falls[3]) begin
              st  <= S_NREAD;
              cnt <= POS_W'(READ_WIDTH - 1);
            end
          end
        end
        S_ARMED: begin
          if (hs_evt) begin
            st    <= S_EXPOSE;
            first <= 1'b1;
            if (flick) rem <= LCNT_W'(FLICKER_LINES);
            else rem <= (line_count == '0) ? LCNT_W'(1) : line_count;
          end
        end
        S_EXPOSE: begin
          if (early_go) begin
            st  <= S_READ;
            cnt <= POS_W'(READ_WIDTH - 1);
          end else if (hs_evt) begin
            first <= 1'b0;
            if (rem <= LCNT_W'(1)) st <= S_ACCUM;
            else rem <= rem - 1'b1;
          end
        end
        S_ACCUM: begin
          if (early_go || pos == POS_W'(RD_POS - 1)) begin
            st  <= S_READ;
            cnt <= POS_W'(READ_WIDTH - 1);
          end
        end
        S_READ: begin
          first <= 1'b0;
          if (cnt == '0) begin
            st  <= S_HOLD;
            cnt <= POS_W'(CLKS_PER_LINE - 1);
          end else cnt <= cnt - 1'b1;
        end
        S_HOLD: begin
          if (cnt == '0) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        S_NREAD: begin
          if (cnt == '0) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy_o    = (st == S_EXPOSE) || (st == S_ACCUM) || (st == S_READ) || (st == S_HOLD);
  assign sub_o     = (st == S_EXPOSE) && first &&
                     (pos >= POS_W'(SUB_START)) && (pos < POS_W'(SUB_END));
  assign readout_o = (st == S_READ) || (st == S_NREAD);
  assign err_o     = err_q;
endmodule

// File: rtl/trig_exposure_ctrl_chk.sv
module trig_exposure_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic busy_o,
  input logic sub_o,
  input logic readout_o,
  input logic err_o
);
  AST_SUB_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sub_o |-> busy_o); // R6
  AST_SUB_READ_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(sub_o && readout_o)); // R4
  AST_BUSY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $fell(readout_o)) |=> busy_o); // R7
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o); // R11
  AST_BUSY_RISE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (!readout_o && !sub_o)); // R2
endmodule

bind trig_exposure_ctrl trig_exposure_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .sub_o(sub_o),
  .readout_o(readout_o), .err_o(err_o)
);

// File: tb/trig_exposure_ctrl_tb_top.sv
module trig_exposure_ctrl_tb_top;
  localparam int L = 64;
  localparam int FL = 5;
  localparam int ACC = 12;
  localparam int SST = 8;
  localparam int SW = 4;
  localparam int WO = 3;
  localparam int RW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_sync_n = 1'b1, trig_n = 1'b1, early_n = 1'b1, discharge_n = 1'b1;
  logic early_mode_n = 1'b1;
  logic [1:0] shutter_mode = 2'b10;
  logic [9:0] line_count = 10'd1;
  logic busy_o, sub_o, readout_o, err_o;
  logic line_sync_n;
  int tb_pos = 0;

  int n_tests = 0, n_fail = 0, cyc = 0;
  int rd_rises = 0, busy_rises = 0, sub_rises = 0, err_pulses = 0;
  int t_subrise = 0, t_subfall = 0, t_rdrise = 0, t_rdfall = 0, t_busyrise = 0, t_busyfall = 0;
  logic p_sub = 1'b0, p_rd = 1'b0, p_busy = 1'b0;

  always #10 clk = ~clk;

  always @(negedge clk) tb_pos <= (tb_pos == L - 1) ? 0 : tb_pos + 1;
  assign line_sync_n = !(tb_pos < 4);

  trig_exposure_ctrl #(
    .CLKS_PER_LINE(L), .FLICKER_LINES(FL), .ACCUM_CLKS(ACC), .SUB_START(SST),
    .SUB_WIDTH(SW), .WIN_OFS(WO), .READ_WIDTH(RW), .LCNT_W(10)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .line_sync_n(line_sync_n), .frame_sync_n(frame_sync_n),
    .trig_n(trig_n), .early_n(early_n), .discharge_n(discharge_n),
    .early_mode_n(early_mode_n), .shutter_mode(shutter_mode), .line_count(line_count),
    .busy_o(busy_o), .sub_o(sub_o), .readout_o(readout_o), .err_o(err_o)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    p_sub <= sub_o; p_rd <= readout_o; p_busy <= busy_o;
    if (sub_o && !p_sub) begin sub_rises <= sub_rises + 1; t_subrise <= cyc; end
    if (!sub_o && p_sub) t_subfall <= cyc;
    if (readout_o && !p_rd) begin rd_rises <= rd_rises + 1; t_rdrise <= cyc; end
    if (!readout_o && p_rd) t_rdfall <= cyc;
    if (busy_o && !p_busy) begin busy_rises <= busy_rises + 1; t_busyrise <= cyc; end
    if (!busy_o && p_busy) t_busyfall <= cyc;
    if (err_o) err_pulses <= err_pulses + 1;
  end

  typedef struct packed {
    logic [1:0] mode;
    logic [9:0] cnt;
    logic       acc;
    logic [9:0] lines;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{2'b10, 10'd3, 1'b1, 10'd3},
    '{2'b10, 10'd1, 1'b1, 10'd1},
    '{2'b00, 10'd7, 1'b1, 10'd5},
    '{2'b11, 10'd3, 1'b0, 10'd0},
    '{2'b01, 10'd3, 1'b0, 10'd0},
    '{2'b10, 10'd0, 1'b1, 10'd1},
    '{2'b10, 10'd6, 1'b1, 10'd6}
  };

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic at_pos(input int p);
    do @(posedge clk); while (tb_pos != p);
    @(negedge clk);
  endtask

  task automatic wait_lines(input int n);
    repeat (n * L) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_trig();
    at_pos(32); trig_n = 1'b0;
    at_pos(32); trig_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int rd0, b0, s0, e0, exp_gap;
    repeat (5) @(negedge clk);
    chk("R1 reset outputs", {busy_o, sub_o, readout_o, err_o} == 4'b0, {busy_o, sub_o, readout_o, err_o}, 0);
    rst_n = 1'b1;
    wait_lines(3);
    chk("R1 idle after reset", {busy_o, sub_o, readout_o, err_o} == 4'b0, {busy_o, sub_o, readout_o, err_o}, 0);

    for (int i = 0; i < 7; i++) begin
      shutter_mode = VEC[i].mode;
      line_count = VEC[i].cnt;
      rd0 = rd_rises; b0 = busy_rises; s0 = sub_rises;
      do_trig();
      wait_lines(int'(VEC[i].lines) + 6);
      if (VEC[i].acc) begin
        exp_gap = int'(VEC[i].lines) * L + ACC;
        chk("R2 busy started", busy_rises - b0 == 1, busy_rises - b0, 1);
        chk("R6 one sub pulse", sub_rises - s0 == 1, sub_rises - s0, 1);
        chk("R6 sub width", t_subfall - t_subrise == SW, t_subfall - t_subrise, SW);
        chk("R6 sub offset", t_subrise - t_busyrise == SST, t_subrise - t_busyrise, SST);
        if (VEC[i].mode == 2'b00)
          chk("R5 flicker gap", t_rdrise - t_subfall == exp_gap, t_rdrise - t_subfall, exp_gap);
        else
          chk("R4 line gap", t_rdrise - t_subfall == exp_gap, t_rdrise - t_subfall, exp_gap);
        chk("R7 read width", t_rdfall - t_rdrise == RW, t_rdfall - t_rdrise, RW);
        chk("R7 busy tail", t_busyfall - t_rdfall == L, t_busyfall - t_rdfall, L);
      end else begin
        chk("R3 reject busy", busy_rises - b0 == 0, busy_rises - b0, 0);
        chk("R3 reject read", rd_rises - rd0 == 0, rd_rises - rd0, 0);
      end
    end

    rd0 = rd_rises; b0 = busy_rises;
    at_pos(32); frame_sync_n = 1'b0;
    at_pos(32); frame_sync_n = 1'b1;
    wait_lines(3);
    chk("R10 idle frame readout", rd_rises - rd0 == 1, rd_rises - rd0, 1);
    chk("R10 idle frame no busy", busy_rises - b0 == 0, busy_rises - b0, 0);
    chk("R10 idle frame width", t_rdfall - t_rdrise == RW, t_rdfall - t_rdrise, RW);

    shutter_mode = 2'b10; line_count = 10'd4;
    rd0 = rd_rises;
    do_trig();
    at_pos(32); frame_sync_n = 1'b0;
    at_pos(32); frame_sync_n = 1'b1;
    wait_lines(8);
    chk("R10 busy frame ignored", rd_rises - rd0 == 1, rd_rises - rd0, 1);
    chk("R10 busy frame timing", t_rdrise - t_subfall == 4 * L + ACC, t_rdrise - t_subfall, 4 * L + ACC);

    early_mode_n = 1'b0; line_count = 10'd8;
    rd0 = rd_rises;
    do_trig();
    at_pos(32); early_n = 1'b0;
    at_pos(32); early_n = 1'b1;
    wait_lines(4);
    exp_gap = L - (SST + SW) + WO + 1;
    chk("R8 early readout time", t_rdrise - t_subfall == exp_gap, t_rdrise - t_subfall, exp_gap);
    chk("R8 single readout", rd_rises - rd0 == 1, rd_rises - rd0, 1);
    chk("R8 busy tail", t_busyfall - t_rdfall == L, t_busyfall - t_rdfall, L);

    early_mode_n = 1'b1;
    rd0 = rd_rises;
    do_trig();
    at_pos(32); early_n = 1'b0;
    at_pos(32); early_n = 1'b1;
    wait_lines(12);
    chk("R9 early ignored", t_rdrise - t_subfall == 8 * L + ACC, t_rdrise - t_subfall, 8 * L + ACC);
    chk("R9 one readout", rd_rises - rd0 == 1, rd_rises - rd0, 1);

    early_mode_n = 1'b0; line_count = 10'd2;
    e0 = err_pulses; b0 = busy_rises;
    at_pos(32); trig_n = 1'b0; early_n = 1'b0;
    at_pos(32); trig_n = 1'b1; early_n = 1'b1;
    wait_lines(4);
    chk("R11 clash error pulse", err_pulses - e0 == 1, err_pulses - e0, 1);
    chk("R11 clash not armed", busy_rises - b0 == 0, busy_rises - b0, 0);
    early_mode_n = 1'b1;

    e0 = err_pulses; b0 = busy_rises;
    at_pos(32); trig_n = 1'b0; discharge_n = 1'b0;
    at_pos(32); trig_n = 1'b1; discharge_n = 1'b1;
    wait_lines(4);
    chk("R11 clash with discharge", err_pulses - e0 == 1 && busy_rises == b0, err_pulses - e0, 1);

    b0 = busy_rises; rd0 = rd_rises;
    at_pos(20); trig_n = 1'b0;
    repeat (5) @(negedge clk);
    trig_n = 1'b1;
    wait_lines(4);
    chk("R12 glitch ignored", busy_rises - b0 == 0 && rd_rises == rd0, busy_rises - b0, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule